// File: doc/BRIEF.md
# Floating-Point Issue Timing Scoreboard

This block decides, one request per cycle, whether a floating-point instruction may enter the pipeline. A request carries an operation class, a destination register index with an enable, and up to three source register indices, each with its own enable. The block answers with a combinational `issue` in the same cycle. It keeps a countdown per register for the time until that register's pending result is ready. It also models how long each class occupies the main pipe, and it tracks a shared iterative unit used by divide, square root, reciprocal square root and sine/cosine.

Divide and square root complete out of order. After issue they use the main pipe for one cycle only, so independent work keeps flowing. When the iterative unit finishes, the operation takes one more main-pipe cycle for normalisation and rounding, and no request issues in that cycle. The iterative unit is a three-state machine. `SP_IDLE` goes to `SP_BUSY` on the start of a special-unit operation. `SP_BUSY` goes back to `SP_IDLE` when its occupancy ends, or to `SP_POST` if the operation needs a postprocess cycle. `SP_POST` always returns to `SP_IDLE` one cycle later.

Top module: `fpu_issue_sb`

## Requirements
- R1: After reset every register reads ready, the special unit is idle (`spec_busy`=0, `post_slot`=0), the main pipe is free, and a valid request with no hazards issues at once.
- R2: Class codes on `req_class` are 0 simple add/sub/convert, 1 compare, 2 multiply-class (single multiply, multiply-accumulate, inner product, other double arithmetic), 3 vector transform, 4 double multiply, 5 divide/square root, 6 reciprocal square root, 7 sine/cosine. A consumer of an op issued in cycle t may issue no earlier than cycle t+L, where L is 3, 2, 5, 8, 7, 17, 5, 7 for codes 0 to 7.
- R3: After an issue in cycle t, the next issue of any class is possible no earlier than t+P, where P is 4 for code 3, 3 for codes 4 and 7, and 1 for all others.
- R4: Codes 5, 6 and 7 occupy the special unit for 13, 3 and 5 cycles from their issue cycle. While it is occupied, `spec_busy` is 1 and any further request of these codes stalls.
- R5: A code-5 op issued in cycle t claims the main pipe in cycle t+13. In that cycle `post_slot` is 1 and no request issues. The special unit is free again in t+14.
- R6: Divide/square root completes out of order: an independent request may issue in the cycle after it.
- R7: A request stalls while any enabled source register is not ready. Sources whose enable is 0 are ignored, and all three source slots are checked.
- R8: A request with its destination enabled stalls while that destination still has a pending result.
- R9: With `req_valid` low, `issue` is 0 and no register, pitch or special-unit state changes.
- R10: A square root issued in cycle t, followed by a divide that consumes its result, leaves the divide's destination ready in cycle t+34 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_class | input | 3 | Operation class code (R2) |
| req_dst | input | REG_W | Destination register index |
| req_dst_en | input | 1 | Request writes a destination register |
| req_src | input | NSRC*REG_W | Source register indices, slot-packed |
| req_src_en | input | NSRC | Per-slot source enable |
| issue | output | 1 | Request accepted this cycle |
| reg_ready | output | NREG | Per-register result-ready flags |
| spec_busy | output | 1 | Special iterative unit occupied |
| post_slot | output | 1 | Postprocess cycle is using the main pipe |

## Verification
A register countdown that is off by one shows up as a dependent request issuing one cycle early or late. The same error appears on `reg_ready` in the cycle the result was due. A special-unit state machine stuck in `SP_BUSY`, or one that skips `SP_POST`, shows within 14 cycles of a divide: `post_slot` goes missing or the next special op stalls too long. A wrong pitch count shows on the very next request. The chained square-root-then-divide run measures the total 34-cycle span at the ports, so a small error at either stage cannot be hidden.

// File: rtl/fpu_sb_pkg.sv
package fpu_sb_pkg;

    typedef enum logic [2:0] {
        OPC_SIMPLE  = 3'd0,
        OPC_CMP     = 3'd1,
        OPC_MUL5    = 3'd2,
        OPC_XFORM   = 3'd3,
        OPC_DMUL    = 3'd4,
        OPC_DIVSQRT = 3'd5,
        OPC_RSQRT   = 3'd6,
        OPC_SINCOS  = 3'd7
    } opclass_e;

    localparam int LAT_W   = 5;
    localparam int PITCH_W = 3;
    localparam int SPEC_W  = 4;

    typedef struct packed {
        logic [LAT_W-1:0]   lat;
        logic [PITCH_W-1:0] pitch;
        logic [SPEC_W-1:0]  spec;
        logic               post;
    } timing_t;

    function automatic timing_t class_timing(input opclass_e c);
        timing_t t;
        unique case (c)
            OPC_SIMPLE:  t = '{lat: 5'd3,  pitch: 3'd1, spec: 4'd0,  post: 1'b0};
            OPC_CMP:     t = '{lat: 5'd2,  pitch: 3'd1, spec: 4'd0,  post: 1'b0};
            OPC_MUL5:    t = '{lat: 5'd5,  pitch: 3'd1, spec: 4'd0,  post: 1'b0};
            OPC_XFORM:   t = '{lat: 5'd8,  pitch: 3'd4, spec: 4'd0,  post: 1'b0};
            OPC_DMUL:    t = '{lat: 5'd7,  pitch: 3'd3, spec: 4'd0,  post: 1'b0};
            OPC_DIVSQRT: t = '{lat: 5'd17, pitch: 3'd1, spec: 4'd13, post: 1'b1};
            OPC_RSQRT:   t = '{lat: 5'd5,  pitch: 3'd1, spec: 4'd3,  post: 1'b0};
            OPC_SINCOS:  t = '{lat: 5'd7,  pitch: 3'd3, spec: 4'd5,  post: 1'b0};
            default:     t = '{lat: 5'd3,  pitch: 3'd1, spec: 4'd0,  post: 1'b0};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/fpu_sb_regtrack.sv
module fpu_sb_regtrack #(
    parameter int NREG  = 16,
    parameter int CNT_W = 5,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_idx,
    input  logic [CNT_W-1:0] load_val,
    output logic [NREG-1:0]  ready
);

    logic [CNT_W-1:0] cnt [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        assign hit = load && (load_idx == REG_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt[g] <= '0;
            end else if (hit) begin
                cnt[g] <= load_val;
            end else if (cnt[g] != '0) begin
                cnt[g] <= cnt[g] - 1'b1;
            end
        end

        assign ready[g] = (cnt[g] == '0);

        // R2: a pending countdown falls by exactly one per cycle
        p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] != '0 && !hit) |=> (cnt[g] == $past(cnt[g]) - 1'b1));
    end

    // R8: a destination is only reloaded once its previous result is ready
    p_reload_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ready[load_idx]);

endmodule

// File: rtl/fpu_sb_pitch.sv
module fpu_sb_pitch #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [PW-1:0] pitch,
    output logic          free
);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (issue) begin
            cnt <= pitch - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign free = (cnt == '0);

    // R3: nothing issues while an earlier pitch is still running
    p_pitch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !free |-> !issue);

endmodule

// File: rtl/fpu_sb_special.sv
module fpu_sb_special #(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] occ,
    input  logic          post_req,
    output logic          idle,
    output logic          post_slot
);

    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_BUSY = 2'd1,
        SP_POST = 2'd2
    } sp_state_e;

    sp_state_e     state, state_nx;
    logic [SW-1:0] cnt;
    logic          post_pend;

    always_comb begin
        state_nx = state;
        unique case (state)
            SP_IDLE: if (start) state_nx = SP_BUSY;
            SP_BUSY: if (cnt == SW'(1)) state_nx = post_pend ? SP_POST : SP_IDLE;
            SP_POST: state_nx = SP_IDLE;
            default: state_nx = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SP_IDLE;
            cnt       <= '0;
            post_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == SP_IDLE && start) begin
                cnt       <= occ - 1'b1;
                post_pend <= post_req;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        idle      = 1'b0;
        post_slot = 1'b0;
        unique case (state)
            SP_IDLE: idle = 1'b1;
            SP_BUSY: idle = 1'b0;
            SP_POST: post_slot = 1'b1;
            default: idle = 1'b1;
        endcase
    end

    // R4: a new special operation starts only from the idle state
    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == SP_IDLE));

    // R5: the postprocess state lasts exactly one cycle
    p_post_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SP_POST) |=> (state == SP_IDLE));

endmodule

// File: rtl/fpu_issue_sb.sv
module fpu_issue_sb
    import fpu_sb_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int NSRC  = 3,
    parameter int CNT_W = 5,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [2:0]                 req_class,
    input  logic [REG_W-1:0]           req_dst,
    input  logic                       req_dst_en,
    input  logic [NSRC-1:0][REG_W-1:0] req_src,
    input  logic [NSRC-1:0]            req_src_en,
    output logic                       issue,
    output logic [NREG-1:0]            reg_ready,
    output logic                       spec_busy,
    output logic                       post_slot
);

    timing_t tm;
    logic    main_free;
    logic    sp_idle;
    logic    sp_post;
    logic    raw_hit;
    logic    waw_hit;
    logic    need_sp;

    assign tm      = class_timing(opclass_e'(req_class));
    assign need_sp = (tm.spec != '0);

    always_comb begin
        raw_hit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_src_en[i] && !reg_ready[req_src[i]]) raw_hit = 1'b1;
        end
    end

    assign waw_hit = req_dst_en && !reg_ready[req_dst];

    assign issue = req_valid && !raw_hit && !waw_hit && main_free
                && !sp_post && !(need_sp && !sp_idle);

    fpu_sb_regtrack #(.NREG(NREG), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue && req_dst_en),
        .load_idx (req_dst),
        .load_val (CNT_W'(tm.lat - 1'b1)),
        .ready    (reg_ready)
    );

    fpu_sb_pitch #(.PW(PITCH_W)) u_pitch (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue),
        .pitch (tm.pitch),
        .free  (main_free)
    );

    fpu_sb_special #(.SW(SPEC_W)) u_special (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (issue && need_sp),
        .occ       (tm.spec),
        .post_req  (tm.post),
        .idle      (sp_idle),
        .post_slot (sp_post)
    );

    assign spec_busy = !sp_idle;
    assign post_slot = sp_post;

    // R5: the postprocess cycle owns the main pipe
    p_post_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        post_slot |-> !issue);

    // R9: no issue without a valid request
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !issue);

    // R7: every enabled source of an issued request is ready
    for (genvar g = 0; g < NSRC; g++) begin : g_raw
        p_raw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && req_src_en[g]) |-> reg_ready[req_src[g]]);
    end

endmodule

// File: tb/fpu_issue_sb_bench.sv
module fpu_issue_sb_bench;
    import fpu_sb_pkg::*;

    localparam int NREG = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [2:0]       req_class;
    logic [3:0]       req_dst;
    logic             req_dst_en;
    logic [2:0][3:0]  req_src;
    logic [2:0]       req_src_en;
    logic             issue;
    logic [NREG-1:0]  reg_ready;
    logic             spec_busy;
    logic             post_slot;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpu_issue_sb u_fpu_issue_sb (
        .clk, .rst_n, .req_valid, .req_class, .req_dst, .req_dst_en,
        .req_src, .req_src_en, .issue, .reg_ready, .spec_busy, .post_slot
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic attempt(input logic [2:0] c, input logic [3:0] d, input logic de,
                           input logic [3:0] s, input logic se, input int slot,
                           output logic ok, output int at);
        @(negedge clk);
        req_valid  = 1'b1;
        req_class  = c;
        req_dst    = d;
        req_dst_en = de;
        req_src    = '0;
        req_src_en = '0;
        req_src[slot]    = s;
        req_src_en[slot] = se;
        #1;
        ok = issue;
        at = cyc;
    endtask

    task automatic retry(input logic [2:0] c, input logic [3:0] d, input logic de,
                         input logic [3:0] s, input logic se, output int at);
        logic ok;
        int   t;
        at = -1;
        for (int k = 0; k < 60; k++) begin
            attempt(c, d, de, s, se, 0, ok, t);
            if (ok) begin
                at = t;
                break;
            end
        end
    endtask

    task automatic drain();
        @(negedge clk);
        req_valid = 1'b0;
        repeat (25) @(posedge clk);
    endtask

    task automatic t_reset();
        logic ok;
        int   t;
        check(reg_ready == '1, "R1 all ready", int'(reg_ready), 16'hffff);
        check(!spec_busy && !post_slot, "R1 special idle", {spec_busy, post_slot}, 0);
        attempt(OPC_SIMPLE, 4'd0, 1'b1, 4'd0, 1'b0, 0, ok, t);
        check(ok, "R1 first issue", ok, 1);
    endtask

    task automatic t_latency(input logic [2:0] c, input int exp);
        logic ok;
        int   t0, t1;
        drain();
        attempt(c, 4'd1, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        retry(OPC_SIMPLE, 4'd2, 1'b0, 4'd1, 1'b1, t1);
        check(ok && (t1 - t0 == exp), $sformatf("R2 latency class %0d", c), t1 - t0, exp);
    endtask

    task automatic t_pitch(input logic [2:0] c, input int exp, input string req);
        logic ok;
        int   t0, t1;
        drain();
        attempt(c, 4'd1, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        retry(OPC_SIMPLE, 4'd2, 1'b0, 4'd0, 1'b0, t1);
        check(ok && (t1 - t0 == exp), $sformatf("%s pitch class %0d", req, c), t1 - t0, exp);
    endtask

    task automatic t_special();
        logic ok;
        int   t0, t1;
        drain();
        attempt(OPC_RSQRT, 4'd1, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(spec_busy, "R4 busy after start", spec_busy, 1);
        retry(OPC_RSQRT, 4'd2, 1'b1, 4'd0, 1'b0, t1);
        check(ok && (t1 - t0 == 3), "R4 rsqrt occupancy", t1 - t0, 3);
        drain();
        attempt(OPC_DIVSQRT, 4'd1, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        retry(OPC_SINCOS, 4'd2, 1'b1, 4'd0, 1'b0, t1);
        check(ok && (t1 - t0 == 14), "R4 divide occupancy", t1 - t0, 14);
    endtask

    task automatic t_post();
        logic ok;
        int   t0, t;
        drain();
        attempt(OPC_DIVSQRT, 4'd1, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        for (int k = 1; k <= 14; k++) begin
            attempt(OPC_SIMPLE, 4'd0, 1'b0, 4'd0, 1'b0, 0, ok, t);
            if (k == 1)  check(ok, "R6 issue after divide", ok, 1);
            if (k == 12) check(ok && !post_slot, "R5 before post", {ok, post_slot}, 2);
            if (k == 13) check(!ok && post_slot, "R5 post slot", {ok, post_slot}, 1);
            if (k == 14) check(ok && !post_slot, "R5 after post", {ok, post_slot}, 2);
        end
    endtask

    task automatic t_hazards();
        logic ok;
        int   t0, t1;
        drain();
        attempt(OPC_DIVSQRT, 4'd5, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        retry(OPC_SIMPLE, 4'd5, 1'b1, 4'd0, 1'b0, t1);
        check(ok && (t1 - t0 == 17), "R8 write-after-write", t1 - t0, 17);
        drain();
        attempt(OPC_DIVSQRT, 4'd6, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        attempt(OPC_SIMPLE, 4'd7, 1'b1, 4'd6, 1'b0, 2, ok, t1);
        check(ok, "R7 disabled source ignored", ok, 1);
        attempt(OPC_SIMPLE, 4'd8, 1'b1, 4'd6, 1'b1, 2, ok, t1);
        check(!ok, "R7 slot 2 source stalls", ok, 0);
    endtask

    task automatic t_idle();
        drain();
        @(negedge clk);
        req_valid  = 1'b0;
        req_class  = OPC_XFORM;
        req_dst    = 4'd3;
        req_dst_en = 1'b1;
        req_src_en = '0;
        #1;
        check(!issue, "R9 no issue when invalid", issue, 0);
        @(negedge clk);
        #1;
        check(reg_ready[3] && !spec_busy, "R9 no state change", {reg_ready[3], spec_busy}, 2);
        req_valid = 1'b1;
        req_class = OPC_SIMPLE;
        req_dst_en = 1'b0;
        #1;
        check(issue, "R9 pipe not occupied", issue, 1);
    endtask

    task automatic t_chain();
        logic ok;
        int   t0, t1;
        drain();
        attempt(OPC_DIVSQRT, 4'd2, 1'b1, 4'd0, 1'b0, 0, ok, t0);
        retry(OPC_DIVSQRT, 4'd3, 1'b1, 4'd2, 1'b1, t1);
        check(ok && (t1 - t0 == 17), "R10 divide waits for root", t1 - t0, 17);
        @(negedge clk);
        req_valid = 1'b0;
        while (cyc != t0 + 33) @(negedge clk);
        #1;
        check(!reg_ready[3], "R10 not ready at 33", reg_ready[3], 0);
        @(negedge clk);
        #1;
        check(reg_ready[3], "R10 ready at 34", reg_ready[3], 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_class  = '0;
        req_dst    = '0;
        req_dst_en = 1'b0;
        req_src    = '0;
        req_src_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_latency(OPC_SIMPLE, 3);
        t_latency(OPC_CMP, 2);
        t_latency(OPC_MUL5, 5);
        t_latency(OPC_XFORM, 8);
        t_latency(OPC_DMUL, 7);
        t_latency(OPC_DIVSQRT, 17);
        t_latency(OPC_RSQRT, 5);
        t_latency(OPC_SINCOS, 7);
        t_pitch(OPC_XFORM, 4, "R3");
        t_pitch(OPC_DMUL, 3, "R3");
        t_pitch(OPC_SINCOS, 3, "R3");
        t_pitch(OPC_MUL5, 1, "R3");
        t_pitch(OPC_DIVSQRT, 1, "R6");
        t_special();
        t_post();
        t_hazards();
        t_idle();
        t_chain();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule